// File: doc/BRIEF.md
# Exception Entry and Vector Sequencer

This block is the control sequencer of a small 16-bit processor whose program address is 23 bits wide: a 16-bit program counter joined with a 7-bit program bank above it. It owns the program counter, the bank, the live status word, the vector base and the saved-context registers. It drives a single 16-bit read port into memory, which is used both for instruction prefetch and for reading an exception vector.

The surrounding datapath executes the instruction that the sequencer presents. It then asks the sequencer for one of four things: step to the next word, take a long jump to a new bank and PC, return from an exception, or enter an exception. An exception comes from one of three sources. A software trap and an interrupt each carry their own number. An invalid opcode always uses one fixed number.

On entry the sequencer does the following:
- saves the address of the instruction that was executing, which is the PC minus 2, together with its bank;
- copies the status word into the saved copy and then clears both interrupt enables in the live status word;
- reads the new PC from the vector table and forces the bank to zero;
- prefetches from the new location.

Return from exception restores the status word, the PC and the bank, then prefetches from the restored location.

Top module: `exc_seq`

## Requirements
- R1: A synchronous reset (rst high) clears the PC, the bank, the status word, the vector base and all saved registers to zero. It then leaves the sequencer fetching, with mem_req high at address 0 and instr_valid low.
- R2: A prefetch reads the 23-bit address {pc_bank, pc}. In the cycle after mem_ack, instr holds the word read and instr_valid is high for one cycle, while pc has advanced by 2 and the bank is unchanged.
- R3: While a read is outstanding (mem_req high, mem_ack low), mem_req stays high and mem_addr does not change.
- R4: Exception entry sets saved_pc to the current pc minus 2, saved_bank to the current bank, and saved_sr to the status word as it was before entry.
- R5: Exception entry clears status bits INT0_BIT (default 4) and INT1_BIT (default 5) and leaves every other status bit unchanged.
- R6: The vector read address is vector base + 2 × exception number, computed modulo 2^16, with the bank bits of the address at zero.
- R7: When the vector read completes, pc takes the word read and the bank becomes zero. The next prefetch is from {0, that word}.
- R8: exc_src code 0 (trap) and code 2 (interrupt) take their number from exc_imm. Code 1 (invalid opcode) uses INVALID_NUM (default 6) and ignores exc_imm. Code 3 behaves like code 0.
- R9: Return from exception restores sr from saved_sr, pc from saved_pc and the bank from saved_bank, then prefetches from the restored address.
- R10: Requests are acted on only in the execute state, with priority exception over return over long jump over step. A request that arrives while a read is pending is ignored.
- R11: A long jump loads pc and the bank from jmp_pc and jmp_bank and prefetches from there. Status and vector-base writes take effect only in the execute state, and a status write is dropped in a cycle that takes an exception or a return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| exc_req | input | 1 | Enter an exception |
| exc_src | input | 2 | Source: 0 trap, 1 invalid opcode, 2 interrupt |
| exc_imm | input | 8 | Exception number for trap and interrupt |
| rte_req | input | 1 | Return from exception |
| jmp_req | input | 1 | Long jump |
| jmp_pc | input | 16 | Jump target PC |
| jmp_bank | input | 7 | Jump target bank |
| step_req | input | 1 | Fetch the next sequential word |
| sr_we | input | 1 | Status word write enable |
| sr_wdata | input | 16 | Status word write data |
| vbr_we | input | 1 | Vector base write enable |
| vbr_wdata | input | 16 | Vector base write data |
| mem_req | output | 1 | Read request |
| mem_addr | output | 23 | Read address |
| mem_rdata | input | 16 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Read completes this cycle |
| instr | output | 16 | Prefetched instruction word |
| instr_valid | output | 1 | One-cycle pulse when a new instruction word is present |
| pc | output | 16 | Program counter |
| pc_bank | output | 7 | Program bank (address bits 22:16) |
| sr | output | 16 | Live status word |
| saved_pc | output | 16 | PC saved on exception entry |
| saved_bank | output | 7 | Bank saved on exception entry |
| saved_sr | output | 16 | Status word saved on exception entry |

## Verification
The bench sweeps all three exception sources over sixteen exception numbers. It starts each case from a different bank, PC and status word, and uses read latencies of zero to two cycles.

Each case is aimed at a specific way the design could go wrong:
- Saving the PC without the minus-2 correction returns execution one word late.
- Saving the live status word after it has been masked loses the interrupt enables on return.
- Keeping the bank across the vector read fetches the handler from the wrong 64K page.
- A vector base of 0xFFF0 forces the table address to wrap modulo 2^16.

Simultaneous requests test the priority order. Requests and status writes are also injected while a fetch is stalled, to show that the sequencer ignores them instead of starting a second exception.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

  typedef enum logic [1:0] {
    ST_NORMAL     = 2'd0,
    ST_EXC_START  = 2'd1,
    ST_VEC_FETCH  = 2'd2,
    ST_NEED_FETCH = 2'd3
  } seq_state_e;

  localparam logic [1:0] SRC_TRAP    = 2'd0;
  localparam logic [1:0] SRC_ILLEGAL = 2'd1;
  localparam logic [1:0] SRC_IRQ     = 2'd2;

endpackage

// File: rtl/exc_seq_fsm.sv
module exc_seq_fsm
  import exc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       exc_req,
  input  logic       rte_req,
  input  logic       jmp_req,
  input  logic       step_req,
  input  logic       mem_ack,
  output seq_state_e state,
  output logic       in_norm,
  output logic       ev_exc,
  output logic       ev_rte,
  output logic       ev_jmp,
  output logic       ev_fetch,
  output logic       ev_vector,
  output logic       ev_enter
);

  seq_state_e state_nx;
  logic       ev_step;

  // Request arbitration: exception > return > jump > step, only in NORMAL.
  always_comb begin
    in_norm   = (state == ST_NORMAL);
    ev_exc    = in_norm && exc_req;
    ev_rte    = in_norm && !exc_req && rte_req;
    ev_jmp    = in_norm && !exc_req && !rte_req && jmp_req;
    ev_step   = in_norm && !exc_req && !rte_req && !jmp_req && step_req;
    ev_fetch  = (state == ST_NEED_FETCH) && mem_ack;
    ev_vector = (state == ST_VEC_FETCH) && mem_ack;
    ev_enter  = (state == ST_EXC_START);
  end

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_NORMAL: begin
        if (ev_exc)
          state_nx = ST_EXC_START;
        else if (ev_rte || ev_jmp || ev_step)
          state_nx = ST_NEED_FETCH;
      end
      ST_EXC_START:  state_nx = ST_VEC_FETCH;
      ST_VEC_FETCH:  if (mem_ack) state_nx = ST_NEED_FETCH;
      ST_NEED_FETCH: if (mem_ack) state_nx = ST_NORMAL;
      default:       state_nx = ST_NEED_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_NEED_FETCH;
    else     state <= state_nx;
  end

  // R3: a pending vector read holds the sequencer in place
  p_vec_stall_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_VEC_FETCH && !mem_ack) |=> (state == ST_VEC_FETCH));

  // R10: an exception request taken in NORMAL always starts entry
  p_exc_first_r10: assert property (@(posedge clk) disable iff (rst)
    (state == ST_NORMAL && exc_req) |=> (state == ST_EXC_START));

  // R10: requests outside NORMAL never start entry
  p_ignore_busy_r10: assert property (@(posedge clk) disable iff (rst)
    (state == ST_NEED_FETCH) |=> (state != ST_EXC_START));

endmodule

// File: rtl/exc_seq_addr.sv
module exc_seq_addr
  import exc_seq_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int BANK_W = 7,
  parameter int NUM_W  = 8,
  localparam int ADDR_W = PC_W + BANK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  seq_state_e        state,
  input  logic [PC_W-1:0]   pc,
  input  logic [BANK_W-1:0] bank,
  input  logic [PC_W-1:0]   vbr,
  input  logic [NUM_W-1:0]  exc_num,
  input  logic              mem_ack,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr
);

  // Program address: bank bits sit directly above the 16-bit PC.
  function automatic logic [ADDR_W-1:0] fetch_addr(input logic [BANK_W-1:0] b,
                                                  input logic [PC_W-1:0]   p);
    return {b, p};
  endfunction

  // Vector slot: base plus two bytes per entry, wrapping in the PC width.
  function automatic logic [ADDR_W-1:0] vector_addr(input logic [PC_W-1:0]  base,
                                                   input logic [NUM_W-1:0] n);
    logic [PC_W-1:0] off;
    logic [PC_W-1:0] sum;
    off = PC_W'(n) << 1;
    sum = base + off;
    return ADDR_W'(sum);
  endfunction

  always_comb begin
    mem_req  = (state == ST_NEED_FETCH) || (state == ST_VEC_FETCH);
    mem_addr = (state == ST_VEC_FETCH) ? vector_addr(vbr, exc_num)
                                       : fetch_addr(bank, pc);
  end

  // R3: request and address hold until acknowledged
  p_addr_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  // R6: vector reads never carry bank bits
  p_vec_bank_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_VEC_FETCH) |-> (mem_addr[ADDR_W-1:PC_W] == '0));

endmodule

// File: rtl/exc_seq_ctx.sv
module exc_seq_ctx
  import exc_seq_pkg::*;
#(
  parameter int PC_W       = 16,
  parameter int BANK_W     = 7,
  parameter int NUM_W      = 8,
  parameter int SR_W       = 16,
  parameter int INT0_BIT   = 4,
  parameter int INT1_BIT   = 5,
  parameter int INVALID_NUM = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_norm,
  input  logic              ev_exc,
  input  logic              ev_rte,
  input  logic              ev_jmp,
  input  logic              ev_fetch,
  input  logic              ev_vector,
  input  logic              ev_enter,
  input  logic [1:0]        exc_src,
  input  logic [NUM_W-1:0]  exc_imm,
  input  logic [PC_W-1:0]   jmp_pc,
  input  logic [BANK_W-1:0] jmp_bank,
  input  logic              sr_we,
  input  logic [SR_W-1:0]   sr_wdata,
  input  logic              vbr_we,
  input  logic [PC_W-1:0]   vbr_wdata,
  input  logic [PC_W-1:0]   mem_rdata,
  output logic [PC_W-1:0]   pc,
  output logic [BANK_W-1:0] bank,
  output logic [SR_W-1:0]   sr,
  output logic [PC_W-1:0]   saved_pc,
  output logic [BANK_W-1:0] saved_bank,
  output logic [SR_W-1:0]   saved_sr,
  output logic [PC_W-1:0]   vbr,
  output logic [NUM_W-1:0]  exc_num
);

  localparam logic [PC_W-1:0] WORD_BYTES = PC_W'(2);

  function automatic logic [PC_W-1:0] advance_pc(input logic [PC_W-1:0] p);
    return p + WORD_BYTES;
  endfunction

  // The PC already points past the prefetched word; step back one word.
  function automatic logic [PC_W-1:0] rewind_pc(input logic [PC_W-1:0] p);
    return p - WORD_BYTES;
  endfunction

  function automatic logic [SR_W-1:0] mask_ints(input logic [SR_W-1:0] s);
    logic [SR_W-1:0] m;
    m = '0;
    m[INT0_BIT] = 1'b1;
    m[INT1_BIT] = 1'b1;
    return s & ~m;
  endfunction

  function automatic logic [NUM_W-1:0] pick_num(input logic [1:0]       src,
                                               input logic [NUM_W-1:0] imm);
    return (src == SRC_ILLEGAL) ? NUM_W'(INVALID_NUM) : imm;
  endfunction

  logic sr_take;
  logic vbr_take;

  always_comb begin
    sr_take  = sr_we && in_norm && !ev_exc && !ev_rte;
    vbr_take = vbr_we && in_norm;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= '0;
    end else if (ev_fetch) begin
      pc <= advance_pc(pc);
    end else if (ev_vector) begin
      pc <= mem_rdata;
    end else if (ev_rte) begin
      pc <= saved_pc;
    end else if (ev_jmp) begin
      pc <= jmp_pc;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bank <= '0;
    end else if (ev_vector) begin
      bank <= '0;
    end else if (ev_rte) begin
      bank <= saved_bank;
    end else if (ev_jmp) begin
      bank <= jmp_bank;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sr <= '0;
    end else if (ev_enter) begin
      sr <= mask_ints(sr);
    end else if (ev_rte) begin
      sr <= saved_sr;
    end else if (sr_take) begin
      sr <= sr_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      saved_pc   <= '0;
      saved_bank <= '0;
      saved_sr   <= '0;
    end else if (ev_enter) begin
      saved_pc   <= rewind_pc(pc);
      saved_bank <= bank;
      saved_sr   <= sr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vbr     <= '0;
      exc_num <= '0;
    end else begin
      if (vbr_take) vbr <= vbr_wdata;
      if (ev_exc)   exc_num <= pick_num(exc_src, exc_imm);
    end
  end

  // R4: saved context reflects the pre-entry PC, bank and status
  p_saved_ctx_r4: assert property (@(posedge clk) disable iff (rst)
    ev_enter |=> (saved_pc == $past(pc) - WORD_BYTES) &&
                 (saved_bank == $past(bank)) && (saved_sr == $past(sr)));

  // R5: both interrupt enables are low after entry
  p_int_clear_r5: assert property (@(posedge clk) disable iff (rst)
    ev_enter |=> (!sr[INT0_BIT] && !sr[INT1_BIT]));

  // R7: handler starts in bank zero at the vector word
  p_bank_zero_r7: assert property (@(posedge clk) disable iff (rst)
    ev_vector |=> (bank == '0) && (pc == $past(mem_rdata)));

  // R9: return restores status, PC and bank
  p_rte_restore_r9: assert property (@(posedge clk) disable iff (rst)
    ev_rte |=> (sr == $past(saved_sr)) && (pc == $past(saved_pc)) &&
               (bank == $past(saved_bank)));

  // R2: a completed fetch moves the PC by one word and keeps the bank
  p_fetch_inc_r2: assert property (@(posedge clk) disable iff (rst)
    ev_fetch |=> (pc == $past(pc) + WORD_BYTES) && $stable(bank));

endmodule

// File: rtl/exc_seq.sv
module exc_seq
  import exc_seq_pkg::*;
#(
  parameter int PC_W        = 16,
  parameter int BANK_W      = 7,
  parameter int NUM_W       = 8,
  parameter int SR_W        = 16,
  parameter int INT0_BIT    = 4,
  parameter int INT1_BIT    = 5,
  parameter int INVALID_NUM = 6,
  localparam int ADDR_W     = PC_W + BANK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              exc_req,
  input  logic [1:0]        exc_src,
  input  logic [NUM_W-1:0]  exc_imm,
  input  logic              rte_req,
  input  logic              jmp_req,
  input  logic [PC_W-1:0]   jmp_pc,
  input  logic [BANK_W-1:0] jmp_bank,
  input  logic              step_req,
  input  logic              sr_we,
  input  logic [SR_W-1:0]   sr_wdata,
  input  logic              vbr_we,
  input  logic [PC_W-1:0]   vbr_wdata,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [PC_W-1:0]   mem_rdata,
  input  logic              mem_ack,
  output logic [PC_W-1:0]   instr,
  output logic              instr_valid,
  output logic [PC_W-1:0]   pc,
  output logic [BANK_W-1:0] pc_bank,
  output logic [SR_W-1:0]   sr,
  output logic [PC_W-1:0]   saved_pc,
  output logic [BANK_W-1:0] saved_bank,
  output logic [SR_W-1:0]   saved_sr
);

  seq_state_e        state;
  logic              in_norm;
  logic              ev_exc;
  logic              ev_rte;
  logic              ev_jmp;
  logic              ev_fetch;
  logic              ev_vector;
  logic              ev_enter;
  logic [PC_W-1:0]   vbr;
  logic [NUM_W-1:0]  exc_num;

  exc_seq_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .exc_req   (exc_req),
    .rte_req   (rte_req),
    .jmp_req   (jmp_req),
    .step_req  (step_req),
    .mem_ack   (mem_ack),
    .state     (state),
    .in_norm   (in_norm),
    .ev_exc    (ev_exc),
    .ev_rte    (ev_rte),
    .ev_jmp    (ev_jmp),
    .ev_fetch  (ev_fetch),
    .ev_vector (ev_vector),
    .ev_enter  (ev_enter)
  );

  exc_seq_ctx #(
    .PC_W        (PC_W),
    .BANK_W      (BANK_W),
    .NUM_W       (NUM_W),
    .SR_W        (SR_W),
    .INT0_BIT    (INT0_BIT),
    .INT1_BIT    (INT1_BIT),
    .INVALID_NUM (INVALID_NUM)
  ) u_ctx (
    .clk        (clk),
    .rst        (rst),
    .in_norm    (in_norm),
    .ev_exc     (ev_exc),
    .ev_rte     (ev_rte),
    .ev_jmp     (ev_jmp),
    .ev_fetch   (ev_fetch),
    .ev_vector  (ev_vector),
    .ev_enter   (ev_enter),
    .exc_src    (exc_src),
    .exc_imm    (exc_imm),
    .jmp_pc     (jmp_pc),
    .jmp_bank   (jmp_bank),
    .sr_we      (sr_we),
    .sr_wdata   (sr_wdata),
    .vbr_we     (vbr_we),
    .vbr_wdata  (vbr_wdata),
    .mem_rdata  (mem_rdata),
    .pc         (pc),
    .bank       (pc_bank),
    .sr         (sr),
    .saved_pc   (saved_pc),
    .saved_bank (saved_bank),
    .saved_sr   (saved_sr),
    .vbr        (vbr),
    .exc_num    (exc_num)
  );

  exc_seq_addr #(
    .PC_W   (PC_W),
    .BANK_W (BANK_W),
    .NUM_W  (NUM_W)
  ) u_addr (
    .clk      (clk),
    .rst      (rst),
    .state    (state),
    .pc       (pc),
    .bank     (pc_bank),
    .vbr      (vbr),
    .exc_num  (exc_num),
    .mem_ack  (mem_ack),
    .mem_req  (mem_req),
    .mem_addr (mem_addr)
  );

  // Prefetch register: the word presented to the datapath.
  always_ff @(posedge clk) begin
    if (rst) begin
      instr       <= '0;
      instr_valid <= 1'b0;
    end else begin
      instr_valid <= ev_fetch;
      if (ev_fetch) instr <= mem_rdata;
    end
  end

  // R2: the valid pulse carries the word that was just read
  p_instr_word_r2: assert property (@(posedge clk) disable iff (rst)
    ev_fetch |=> (instr_valid && instr == $past(mem_rdata)));

  // R1: reset leaves a fetch pending at address zero
  p_reset_fetch_r1: assert property (@(posedge clk)
    $past(rst) && rst |-> (mem_req && mem_addr == '0 && !instr_valid));

endmodule

// File: tb/exc_seq_tb.sv
module exc_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] INT_MASK = 16'h0030;
  localparam logic [7:0]  BAD_NUM  = 8'd6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        exc_req = 1'b0;
  logic [1:0]  exc_src = 2'd0;
  logic [7:0]  exc_imm = 8'd0;
  logic        rte_req = 1'b0;
  logic        jmp_req = 1'b0;
  logic [15:0] jmp_pc = 16'd0;
  logic [6:0]  jmp_bank = 7'd0;
  logic        step_req = 1'b0;
  logic        sr_we = 1'b0;
  logic [15:0] sr_wdata = 16'd0;
  logic        vbr_we = 1'b0;
  logic [15:0] vbr_wdata = 16'd0;
  logic        mem_req;
  logic [22:0] mem_addr;
  logic [15:0] mem_rdata = 16'd0;
  logic        mem_ack = 1'b0;
  logic [15:0] instr;
  logic        instr_valid;
  logic [15:0] pc;
  logic [6:0]  pc_bank;
  logic [15:0] sr;
  logic [15:0] saved_pc;
  logic [6:0]  saved_bank;
  logic [15:0] saved_sr;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_seq dut_i (
    .clk(clk), .rst(rst), .exc_req(exc_req), .exc_src(exc_src), .exc_imm(exc_imm),
    .rte_req(rte_req), .jmp_req(jmp_req), .jmp_pc(jmp_pc), .jmp_bank(jmp_bank),
    .step_req(step_req), .sr_we(sr_we), .sr_wdata(sr_wdata), .vbr_we(vbr_we),
    .vbr_wdata(vbr_wdata), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .instr(instr),
    .instr_valid(instr_valid), .pc(pc), .pc_bank(pc_bank), .sr(sr),
    .saved_pc(saved_pc), .saved_bank(saved_bank), .saved_sr(saved_sr)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // Memory contents are a function of the address; always even.
  function automatic logic [15:0] mw(input logic [22:0] a);
    logic [15:0] v;
    v = (a[15:0] * 16'h9E37) ^ {a[22:16], 9'h0};
    return v & 16'hFFFE;
  endfunction

  // Memory model: latency in cycles, records served addresses.
  int          lat = 0;
  int          waitc = 0;
  int          stall_bad = 0;
  logic [22:0] first_addr = '0;
  logic [22:0] srv_prev = '0;
  logic [22:0] srv_last = '0;

  always @(negedge clk) begin
    mem_ack = 1'b0;
    if (!rst && mem_req) begin
      if (waitc == 0) first_addr = mem_addr;
      else if (mem_addr !== first_addr) stall_bad++;
      if (waitc >= lat) begin
        mem_ack   = 1'b1;
        mem_rdata = mw(mem_addr);
        srv_prev  = srv_last;
        srv_last  = mem_addr;
        waitc     = 0;
      end else begin
        waitc++;
      end
    end
  end

  task automatic wait_valid(input string req);
    for (int i = 0; i < 40; i++) begin
      if (instr_valid) return;
      @(negedge clk);
    end
    chk({req, " fetch timeout"}, 32'd0, 32'd1);
  endtask

  task automatic step_cycle();
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog act=hung exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [6:0]  b;
    logic [15:0] p, s, v, vw;
    logic [7:0]  num;
    logic [22:0] va;

    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 pc", 32'(pc), 32'd0);
    chk("R1 bank", 32'(pc_bank), 32'd0);
    chk("R1 sr", 32'(sr), 32'd0);
    chk("R1 saved", {saved_pc, 9'd0, saved_bank}, 32'd0);
    chk("R1 saved_sr", 32'(saved_sr), 32'd0);
    chk("R1 req", {31'd0, mem_req}, 32'd1);
    chk("R1 addr", 32'(mem_addr), 32'd0);
    chk("R1 valid", {31'd0, instr_valid}, 32'd0);
    rst = 1'b0;
    wait_valid("R1");
    chk("R2 first fetch addr", 32'(srv_last), 32'd0);
    chk("R2 first word", 32'(instr), 32'(mw(23'd0)));
    chk("R2 pc step", 32'(pc), 32'd2);

    // R1: vector base is zero after reset -> vector at 2*3
    exc_req = 1'b1; exc_src = 2'd0; exc_imm = 8'd3;
    step_cycle(); exc_req = 1'b0;
    wait_valid("R1");
    chk("R1 vbr zero vector addr", 32'(srv_prev), 32'd6);
    chk("R7 pc from vector", 32'(pc), 32'(mw(23'd6) + 16'd2));

    // R2: sequential step
    lat = 2;
    p = pc;
    step_req = 1'b1; step_cycle(); step_req = 1'b0;
    wait_valid("R2");
    chk("R2 step addr", 32'(srv_last), 32'(p));
    chk("R2 step pc", 32'(pc), 32'(p + 16'd2));
    chk("R2 step word", 32'(instr), 32'(mw(23'(p))));

    for (int src = 0; src < 3; src++) begin
      for (int n = 0; n < 16; n++) begin
        int it;
        it  = src * 16 + n;
        lat = it % 3;
        b   = 7'((it * 37 + 5) & 32'h7F);
        p   = 16'((it * 32'h1357 + 32'h0100) & 32'hFFFE);
        s   = 16'(it * 32'h0F3B) ^ 16'h0030;
        v   = (it % 4 == 3) ? 16'hFFF0 : 16'(it * 32'h0200);

        // R11: long jump to bank b, pc p
        jmp_req = 1'b1; jmp_pc = p; jmp_bank = b;
        step_cycle(); jmp_req = 1'b0;
        wait_valid("R11");
        chk("R11 jump fetch addr", 32'(srv_last), 32'({b, p}));
        chk("R2 banked word", 32'(instr), 32'(mw({b, p})));
        chk("R2 banked pc", 32'(pc), 32'(p + 16'd2));
        chk("R2 bank kept", 32'(pc_bank), 32'(b));

        // R11: status and vector base writes in execute state
        sr_we = 1'b1; sr_wdata = s; vbr_we = 1'b1; vbr_wdata = v;
        step_cycle(); sr_we = 1'b0; vbr_we = 1'b0;
        chk("R11 sr write", 32'(sr), 32'(s));

        // R8/R10: exception with competing requests on odd numbers
        exc_req = 1'b1; exc_src = 2'(src); exc_imm = 8'(n);
        sr_we = (n % 2 == 1); sr_wdata = 16'hDEAD;
        rte_req = (n % 2 == 1); jmp_req = (n % 2 == 1); step_req = (n % 2 == 1);
        jmp_pc = 16'h1234; jmp_bank = 7'h55;
        step_cycle();
        exc_req = 1'b0; rte_req = 1'b0; jmp_req = 1'b0; step_req = 1'b0; sr_we = 1'b0;
        wait_valid("R7");
        num = (src == 1) ? BAD_NUM : 8'(n);
        va  = {7'd0, 16'(v + {7'd0, num, 1'b0})};
        vw  = mw(va);
        chk((src == 1) ? "R8 invalid number vector addr" : "R6 R8 vector addr",
            32'(srv_prev), 32'(va));
        chk("R7 handler fetch addr", 32'(srv_last), 32'({7'd0, vw}));
        chk("R7 handler pc", 32'(pc), 32'(vw + 16'd2));
        chk("R7 bank zero", 32'(pc_bank), 32'd0);
        chk("R4 saved pc", 32'(saved_pc), 32'(p));
        chk("R4 saved bank", 32'(saved_bank), 32'(b));
        chk("R4 R10 saved sr", 32'(saved_sr), 32'(s));
        chk("R5 sr masked", 32'(sr), 32'(s & ~INT_MASK));

        // R9: return; R10: requests during the fetch are ignored
        lat = 2;
        rte_req = 1'b1; step_cycle(); rte_req = 1'b0;
        exc_req = 1'b1; exc_src = 2'd0; exc_imm = 8'hAA;
        sr_we = 1'b1; sr_wdata = ~s;
        step_cycle();
        exc_req = 1'b0; sr_we = 1'b0;
        wait_valid("R9");
        chk("R9 return fetch addr", 32'(srv_last), 32'({b, p}));
        chk("R9 R10 pc", 32'(pc), 32'(p + 16'd2));
        chk("R9 bank", 32'(pc_bank), 32'(b));
        chk("R9 R10 sr restored", 32'(sr), 32'(s));
        chk("R9 return word", 32'(instr), 32'(mw({b, p})));
      end
    end

    chk("R3 address held while stalled", 32'(stall_bad), 32'd0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule